// File: doc/BRIEF.md
# Sleep-Mode Power-Down Sequencer

This block sits between the command decoder of a synchronous memory and its core. It controls when the memory goes into and comes out of a low-power sleep state. Sleep is requested by driving `sleep_req_i` high. A low level means normal operation, so an undriven request tied low keeps the memory awake. The request must stay high for a fixed entry delay of two sampled clock edges. After that the sequencer declares the memory asleep. If the request drops before the delay expires, the sequencer goes back to normal operation and never sleeps.

While asleep, the sequencer does four things:
- it presents a deselect command to the core,
- it raises an input-block flag, so that every pin other than the request is disregarded,
- it raises an output-disable flag, so that the data drivers go to high impedance,
- it leaves the stored contents untouched, because it issues no command that could change them.

When the request falls, a recovery window of a parameterised number of cycles follows. Inside that window, read and deselect commands pass through. Write commands are turned into deselects, and they latch a sticky error flag that only reset clears.

Top module: `slp_sequencer`

## Requirements
- R1: After reset, `asleep_o`, `in_block_o`, `out_hiz_o`, `wr_inhibit_o` and `wr_err_o` are all low, and `cmd_o` equals `cmd_i`.
- R2: From the awake state, `asleep_o` rises after the second consecutive rising edge at which `sleep_req_i` is sampled high. It stays low after the first such edge.
- R3: If `sleep_req_i` is sampled low at the edge after the first high sample, the sequencer returns to the awake state. No sleep and no recovery window follow.
- R4: While `asleep_o` is high, `in_block_o` and `out_hiz_o` are high and `cmd_o` is deselect (2'b00), whatever `cmd_i` carries.
- R5: Sleep persists while the request is sampled high. The first edge at which the request is sampled low drops `asleep_o` and raises `wr_inhibit_o`.
- R6: `wr_inhibit_o` stays high for exactly `RECOVERY_CYCLES` consecutive cycles (8 by default) and then falls.
- R7: During recovery, read (2'b01) and deselect (2'b00) pass to `cmd_o` unchanged. The write codes (2'b10 single, 2'b11 burst continue) appear as deselect.
- R8: A write code during recovery sets `wr_err_o` from the next cycle on. The flag then stays high until reset. Writes outside recovery never set it.
- R9: A request sampled high during recovery neither shortens nor ends the window. If the request is still high when the window ends, entry restarts under R2.
- R10: Outside sleep and recovery, `cmd_o` equals `cmd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| sleep_req_i | input | 1 | Sleep request, active high |
| cmd_i | input | 2 | Decoded command: 00 deselect, 01 read, 10 write, 11 burst-continue write |
| cmd_o | output | 2 | Filtered command towards the memory core |
| asleep_o | output | 1 | Memory is in sleep |
| in_block_o | output | 1 | All inputs except the request are to be ignored |
| out_hiz_o | output | 1 | Data output drivers forced to high impedance |
| wr_inhibit_o | output | 1 | Recovery window active; writes are suppressed |
| wr_err_o | output | 1 | Sticky: a write arrived during recovery |

## Verification
The properties assume that `sleep_req_i` and `cmd_i` are synchronous to the clock and settled before each rising edge. They also assume that `cmd_i` carries only the four defined codes. The stimulus respects this by changing every input only on the falling edge. It draws request levels as runs of random length, so that short aborted entries, long sleeps and requests raised inside the recovery window all occur. Command codes are drawn uniformly from all four values.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL      = 2'b00,
    CMD_READ       = 2'b01,
    CMD_WRITE      = 2'b10,
    CMD_WRITE_CONT = 2'b11
  } slp_cmd_e;

  typedef enum logic [1:0] {
    ST_AWAKE   = 2'b00,
    ST_ENTRY   = 2'b01,
    ST_SLEEP   = 2'b10,
    ST_RECOVER = 2'b11
  } slp_state_e;

  function automatic logic cmd_is_write(input logic [1:0] cmd);
    return cmd[1];
  endfunction

endpackage

// File: rtl/slp_counter.sv
module slp_counter #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] cnt_o
);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i) begin
      cnt_d = cnt_q + WIDTH'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/slp_cmd_gate.sv
module slp_cmd_gate
  import slp_pkg::*;
(
  input  logic [1:0] cmd_i,
  input  logic       block_i,
  input  logic       filter_i,
  output logic [1:0] cmd_o,
  output logic       wr_drop_o
);

  logic is_wr;

  assign is_wr = cmd_is_write(cmd_i);

  always_comb begin
    cmd_o     = cmd_i;
    wr_drop_o = 1'b0;
    if (block_i) begin
      cmd_o = CMD_DESEL;
    end else if (filter_i && is_wr) begin
      cmd_o     = CMD_DESEL;
      wr_drop_o = 1'b1;
    end
  end

endmodule

// File: rtl/slp_sequencer.sv
module slp_sequencer
  import slp_pkg::*;
#(
  parameter int unsigned ENTRY_CYCLES    = 2,
  parameter int unsigned RECOVERY_CYCLES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic [1:0] cmd_i,
  output logic [1:0] cmd_o,
  output logic       asleep_o,
  output logic       in_block_o,
  output logic       out_hiz_o,
  output logic       wr_inhibit_o,
  output logic       wr_err_o
);

  localparam int unsigned ENT_W    = $clog2(ENTRY_CYCLES + 1);
  localparam int unsigned REC_W    = $clog2(RECOVERY_CYCLES + 1);
  localparam logic [ENT_W-1:0] ENT_LAST = ENT_W'(ENTRY_CYCLES - 2);
  localparam logic [REC_W-1:0] REC_LAST = REC_W'(RECOVERY_CYCLES - 1);

  slp_state_e       state_q, state_d;
  logic             state_en;
  logic [ENT_W-1:0] ent_cnt;
  logic [REC_W-1:0] rec_cnt;
  logic             in_entry, in_sleep, in_recover;
  logic             wr_drop;
  logic             err_q, err_d, err_en;

  assign in_entry   = (state_q == ST_ENTRY);
  assign in_sleep   = (state_q == ST_SLEEP);
  assign in_recover = (state_q == ST_RECOVER);

  // counts request-high edges while waiting to enter sleep
  slp_counter #(.WIDTH(ENT_W)) u_ent_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_entry),
    .inc_i  (in_entry && sleep_req_i),
    .cnt_o  (ent_cnt)
  );

  // counts cycles spent in the recovery window
  slp_counter #(.WIDTH(REC_W)) u_rec_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_recover),
    .inc_i  (in_recover),
    .cnt_o  (rec_cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAKE: begin
        if (sleep_req_i) state_d = ST_ENTRY;
      end
      ST_ENTRY: begin
        if (!sleep_req_i)           state_d = ST_AWAKE;
        else if (ent_cnt == ENT_LAST) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (!sleep_req_i) state_d = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (rec_cnt == REC_LAST) state_d = ST_AWAKE;
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  slp_cmd_gate u_gate (
    .cmd_i     (cmd_i),
    .block_i   (in_sleep),
    .filter_i  (in_recover),
    .cmd_o     (cmd_o),
    .wr_drop_o (wr_drop)
  );

  assign err_en = wr_drop && !err_q;
  assign err_d  = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign asleep_o     = in_sleep;
  assign in_block_o   = in_sleep;
  assign out_hiz_o    = in_sleep;
  assign wr_inhibit_o = in_recover;
  assign wr_err_o     = err_q;

endmodule

// File: rtl/slp_sequencer_chk.sv
module slp_sequencer_chk #(
  parameter int unsigned RECOVERY_CYCLES = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_req_i,
  input logic [1:0] cmd_i,
  input logic [1:0] cmd_o,
  input logic       asleep_o,
  input logic       in_block_o,
  input logic       out_hiz_o,
  input logic       wr_inhibit_o,
  input logic       wr_err_o
);

  localparam int unsigned RUN_W = $clog2(RECOVERY_CYCLES + 2);

  logic [RUN_W-1:0] rec_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_run_q <= '0;
    end else if (wr_inhibit_o) begin
      rec_run_q <= rec_run_q + RUN_W'(1);
    end else begin
      rec_run_q <= '0;
    end
  end

  a_r2_entry_needs_two_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(asleep_o) |-> ($past(sleep_req_i) && $past(sleep_req_i, 2)));

  a_r4_sleep_deselects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o |-> (cmd_o == 2'b00 && in_block_o && out_hiz_o));

  a_r5_exit_into_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(asleep_o) |-> (wr_inhibit_o && !$past(sleep_req_i)));

  a_r6_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_run_q <= RUN_W'(RECOVERY_CYCLES));

  a_r6_window_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_inhibit_o) |-> (rec_run_q == RUN_W'(RECOVERY_CYCLES)));

  a_r7_no_write_in_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_inhibit_o |-> !cmd_o[1]);

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |=> wr_err_o);

  a_r8_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_err_o) |-> $past(wr_inhibit_o && cmd_i[1]));

  a_r10_awake_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asleep_o && !wr_inhibit_o) |-> (cmd_o == cmd_i));

endmodule

bind slp_sequencer slp_sequencer_chk #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sleep_req_i  (sleep_req_i),
  .cmd_i        (cmd_i),
  .cmd_o        (cmd_o),
  .asleep_o     (asleep_o),
  .in_block_o   (in_block_o),
  .out_hiz_o    (out_hiz_o),
  .wr_inhibit_o (wr_inhibit_o),
  .wr_err_o     (wr_err_o)
);

// File: tb/slp_sequencer_bench.sv
`timescale 1ns/1ps
module slp_sequencer_bench;

  localparam int REC = 8;
  localparam int S_AWAKE = 0, S_ENTRY = 1, S_SLEEP = 2, S_REC = 3;

  logic       clk;
  logic       rst_n;
  logic       req;
  logic [1:0] cmd;
  logic [1:0] cmd_o;
  logic       asleep, blk, hiz, inh, err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  int m_st, m_ent, m_rec;
  bit m_err;

  slp_sequencer #(.ENTRY_CYCLES(2), .RECOVERY_CYCLES(REC)) u_slp_sequencer (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sleep_req_i  (req),
    .cmd_i        (cmd),
    .cmd_o        (cmd_o),
    .asleep_o     (asleep),
    .in_block_o   (blk),
    .out_hiz_o    (hiz),
    .wr_inhibit_o (inh),
    .wr_err_o     (err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_cmd(input int st, input logic [1:0] c);
    if (st == S_SLEEP) return 2'b00;
    if (st == S_REC && c[1]) return 2'b00;
    return c;
  endfunction

  function automatic string cmd_tag(input int st);
    if (st == S_SLEEP) return "R4";
    if (st == S_REC) return "R7";
    return "R10";
  endfunction

  task automatic model_reset();
    m_st = S_AWAKE; m_ent = 0; m_rec = 0; m_err = 0;
  endtask

  task automatic model_edge(input logic r, input logic [1:0] c);
    if (m_st == S_REC && c[1]) m_err = 1;
    case (m_st)
      S_AWAKE: if (r) begin m_st = S_ENTRY; m_ent = 1; end
      S_ENTRY: begin
        if (!r) m_st = S_AWAKE;
        else begin
          m_ent++;
          if (m_ent >= 2) m_st = S_SLEEP;
        end
      end
      S_SLEEP: if (!r) begin m_st = S_REC; m_rec = 0; end
      default: begin
        m_rec++;
        if (m_rec >= REC) m_st = S_AWAKE;
      end
    endcase
  endtask

  // one cycle: drive on falling edge, check, advance model for the next rising edge
  task automatic step(input logic r, input logic [1:0] c);
    @(negedge clk);
    req = r; cmd = c;
    #1;
    chk("R2", asleep, m_st == S_SLEEP);
    chk("R4", blk, m_st == S_SLEEP);
    chk("R4", hiz, m_st == S_SLEEP);
    chk("R6", inh, m_st == S_REC);
    chk("R8", err, m_err);
    chk(cmd_tag(m_st), cmd_o, exp_cmd(m_st, c));
    model_edge(r, c);
  endtask

  task automatic post();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0; cmd = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    int runlen;
    logic lvl;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req = 1'b0; cmd = 2'b00;
    do_reset();
    #1;
    chk("R1", asleep, 0); chk("R1", inh, 0); chk("R1", err, 0);
    chk("R1", blk, 0); chk("R1", hiz, 0);
    cmd = 2'b10; #1;
    chk("R1", cmd_o, 2'b10);

    // R8: write while awake leaves error clear
    step(1'b0, 2'b10); post(); chk("R8", err, 0);

    // R2 entry
    step(1'b1, 2'b01); post(); chk("R2", asleep, 0);
    step(1'b1, 2'b01); post(); chk("R2", asleep, 1);
    // R4 sleep blocks commands
    step(1'b1, 2'b10);
    step(1'b1, 2'b11);
    step(1'b1, 2'b01); post(); chk("R4", cmd_o, 2'b00); chk("R5", asleep, 1);
    // R5 exit
    step(1'b0, 2'b00); post(); chk("R5", asleep, 0); chk("R5", inh, 1);
    // R6 / R7 / R8 window
    n = 1;
    for (int k = 0; k < 20; k++) begin
      logic [1:0] c;
      c = (k == 1) ? 2'b10 : ((k == 2) ? 2'b11 : 2'b01);
      step(1'b0, c); post();
      if (k == 1) chk("R8", err, 1);
      if (!inh) break;
      n++;
    end
    chk("R6", n, REC);
    step(1'b0, 2'b00); post(); chk("R8", err, 1);

    // R3 abort
    step(1'b1, 2'b01);
    step(1'b0, 2'b01); post();
    chk("R3", asleep, 0); chk("R3", inh, 0); chk("R3", hiz, 0);
    step(1'b0, 2'b10); post(); chk("R3", asleep, 0);

    // R9 request raised during recovery
    step(1'b1, 2'b00); step(1'b1, 2'b00); step(1'b1, 2'b00);
    step(1'b0, 2'b00); post(); chk("R9", inh, 1);
    n = 1;
    for (int k = 0; k < 20; k++) begin
      step(1'b1, 2'b01); post();
      chk("R9", asleep, 0);
      if (!inh) break;
      n++;
    end
    chk("R9", n, REC);
    step(1'b1, 2'b01); post(); chk("R9", asleep, 0);
    step(1'b1, 2'b01); post(); chk("R9", asleep, 1);

    // random phase
    do_reset();
    lvl = 1'b0;
    for (int blkn = 0; blkn < 400; blkn++) begin
      runlen = 1 + int'($urandom_range(13));
      if (($urandom_range(3)) == 0) runlen = 1;
      for (int i = 0; i < runlen; i++) begin
        step(lvl, 2'($urandom_range(3)));
      end
      lvl = ~lvl;
    end
    step(1'b0, 2'b00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule